// File: doc/BRIEF.md
# Directed Rounding Result Corrector

This block sits behind an arithmetic datapath that can only round toward zero or to nearest. It takes the already packed 64-bit result of a floating-point operation or of a float-to-integer conversion, together with the matching source B operand and the per-lane inexact indicators (guard and sticky), and turns it into the result that round-toward-plus-infinity or round-toward-minus-infinity would have produced. The correction is always a single step of one unit in the last place on the packed bits. For magnitude-encoded floating-point values, moving away from zero is an increment. For two's complement integers, moving down is a decrement.

Three precision layouts are handled: one 32-bit lane in the low word, one 64-bit value, and two independent 32-bit lanes. Each lane's sign decides whether it steps. Unsigned conversions count as positive. A signed conversion that produced zero has lost its sign, so the sign is taken from the source operand. Compare operations and the unused precision code are rejected and pass through untouched. The result is registered, and a valid pulse follows each accepted input by one cycle.

Top module: `drc_round_fix`

## Requirements
- R1: After reset out_valid, out_val, out_adj and out_reject are 0. out_valid is 1 exactly in the cycle after a cycle in which in_valid was 1, and the other outputs then hold the result of that input.
- R2: rnd_mode encodings: 0 = to nearest, 1 = toward zero, 2 = toward +infinity, 3 = toward minus infinity. Modes 0 and 1 return dest_val unchanged with out_adj = 0.
- R3: prec_mode encodings: 0 = single (low word, bits 31:0), 1 = double (64 bits), 2 = dual single (low lane 31:0, high lane 63:32). A lane is inexact when its guard or sticky input is 1. Nothing changes unless the low lane is inexact, or prec_mode is 2 and the high lane is inexact. In single mode the high-lane indicators are ignored.
- R4: op_class encodings: 0 = floating-point result, 1 = truncating conversion, 2 = unsigned integer or fraction conversion, 3 = signed integer or fraction conversion. Class 1 is never adjusted, whatever the rounding mode.
- R5: For class 2 every lane counts as positive. Mode 3 leaves it unchanged, and mode 2 increments the inexact lane.
- R6: For class 3, when a lane's 32-bit result is zero, its sign is bit 31 of the same lane of srcb_val (bit 63 for the high lane). Otherwise the sign is the result lane's own bit 31 or bit 63.
- R7: In mode 2 an inexact lane with sign 0 is incremented by one, modulo its lane width.
- R8: In mode 3 an inexact lane with sign 1 steps by one: classes 0 increment, classes 2 and 3 decrement.
- R9: In double mode with class 0, the sign is bit 63 and the step is a 64-bit increment that carries from the low word into the high word.
- R10: In double mode with class 2 or 3, only bits 31:0 step and bits 63:32 are unchanged. The sign is dest_val bit 31, or srcb_val bit 63 when class 3 and bits 31:0 are zero.
- R11: In dual mode each 32-bit lane is corrected on its own sign, gated only by its own inexact indicator, with no carry between the lanes.
- R12: op_class 4 to 7 (4 = compare) or prec_mode 3 sets out_reject = 1 and returns dest_val unchanged with out_adj = 0. Otherwise out_reject = 0.
- R13: out_adj is 1 exactly when out_val differs from the dest_val that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| dest_val | input | DATA_W | Result as rounded by the datapath |
| srcb_val | input | DATA_W | Source B operand of the same operation |
| prec_mode | input | 2 | Precision layout (R3) |
| op_class | input | 3 | Operation class (R4, R12) |
| rnd_mode | input | 2 | Rounding mode (R2) |
| lo_guard | input | 1 | Guard bit of the low lane |
| lo_sticky | input | 1 | Sticky bit of the low lane |
| hi_guard | input | 1 | Guard bit of the high lane |
| hi_sticky | input | 1 | Sticky bit of the high lane |
| out_valid | output | 1 | Registered result is valid |
| out_val | output | DATA_W | Corrected result |
| out_adj | output | 1 | A correction step was applied |
| out_reject | output | 1 | Operation class or layout not accepted |

## Verification
The hardest case to reach is a signed conversion whose result lane is exactly zero while the source operand of that lane is negative. Only then does the recovered source sign, rather than the result's own sign, choose the step. Random 64-bit values almost never produce a zero lane. The stimulus therefore forces each lane to zero with high probability and draws the source sign bits separately. Directed vectors add the carry across the word boundary in double mode and the dual-lane cases where only one lane is inexact.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic [1:0] {
        PREC_SGL  = 2'd0,
        PREC_DBL  = 2'd1,
        PREC_DUAL = 2'd2,
        PREC_RSV  = 2'd3
    } prec_e;

    typedef enum logic [2:0] {
        OPC_FLT   = 3'd0,
        OPC_TRUNC = 3'd1,
        OPC_CVTU  = 3'd2,
        OPC_CVTS  = 3'd3,
        OPC_CMP   = 3'd4,
        OPC_RSV5  = 3'd5,
        OPC_RSV6  = 3'd6,
        OPC_RSV7  = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } rnd_e;

    // Step decision for one input: per-lane +1/-1 and a full-width +1
    typedef struct packed {
        logic reject;
        logic wide_up;
        logic hi_up;
        logic hi_dn;
        logic lo_up;
        logic lo_dn;
    } step_plan_t;

endpackage

// File: rtl/drc_sign_sel.sv
module drc_sign_sel
    import drc_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] dest_lo,
    input  logic              dest_hi_msb,
    input  logic              dest_hi_zero,
    input  logic              srcb_lo_msb,
    input  logic              srcb_hi_msb,
    input  prec_e             prec,
    input  opc_e              opc,
    output logic              sgn_lo,
    output logic              sgn_hi
);

    logic lo_zero;

    always_comb begin
        lo_zero = (dest_lo == '0);
        sgn_lo  = dest_lo[LANE_W-1];
        sgn_hi  = dest_hi_msb;
        if (opc == OPC_CVTU) begin
            sgn_lo = 1'b0;
            sgn_hi = 1'b0;
        end else if (opc == OPC_CVTS) begin
            case (prec)
                PREC_SGL: begin
                    if (lo_zero) sgn_lo = srcb_lo_msb;
                end
                PREC_DUAL: begin
                    if (lo_zero)      sgn_lo = srcb_lo_msb;
                    if (dest_hi_zero) sgn_hi = srcb_hi_msb;
                end
                PREC_DBL: begin
                    // 32-bit integer sits in the low word; the source is a double
                    sgn_hi = lo_zero ? srcb_hi_msb : dest_lo[LANE_W-1];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/drc_step_plan.sv
module drc_step_plan
    import drc_pkg::*;
(
    input  prec_e      prec,
    input  opc_e       opc,
    input  rnd_e       rnd,
    input  logic       inx_lo,
    input  logic       inx_hi,
    input  logic       sgn_lo,
    input  logic       sgn_hi,
    output step_plan_t plan
);

    logic is_fp;
    logic is_int;
    logic directed;
    logic go_up;
    logic gate;
    logic want_lo;
    logic want_hi;

    always_comb begin
        plan        = '0;
        plan.reject = (opc >= OPC_CMP) || (prec == PREC_RSV);
        is_fp       = (opc == OPC_FLT);
        is_int      = (opc == OPC_CVTU) || (opc == OPC_CVTS);
        directed    = (rnd == RND_UP) || (rnd == RND_DOWN);
        go_up       = (rnd == RND_UP);
        gate        = inx_lo || ((prec == PREC_DUAL) && inx_hi);
        // a lane moves when its sign points away from the truncated side
        want_lo     = go_up ? !sgn_lo : sgn_lo;
        want_hi     = go_up ? !sgn_hi : sgn_hi;

        if (!plan.reject && directed && (is_fp || is_int) && gate) begin
            case (prec)
                PREC_SGL: begin
                    if (want_lo) begin
                        plan.lo_up = go_up || is_fp;
                        plan.lo_dn = !go_up && is_int;
                    end
                end
                PREC_DBL: begin
                    if (want_hi) begin
                        plan.wide_up = is_fp;
                        plan.lo_up   = is_int && go_up;
                        plan.lo_dn   = is_int && !go_up;
                    end
                end
                PREC_DUAL: begin
                    if (inx_lo && want_lo) begin
                        plan.lo_up = go_up || is_fp;
                        plan.lo_dn = !go_up && is_int;
                    end
                    if (inx_hi && want_hi) begin
                        plan.hi_up = go_up || is_fp;
                        plan.hi_dn = !go_up && is_int;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/drc_lane_step.sv
module drc_lane_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_in,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] val_out
);

    always_comb begin
        case ({step_up, step_dn})
            2'b10:   val_out = val_in + W'(1);
            2'b01:   val_out = val_in - W'(1);
            default: val_out = val_in;
        endcase
    end

endmodule

// File: rtl/drc_round_fix.sv
module drc_round_fix
    import drc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] dest_val,
    input  logic [DATA_W-1:0] srcb_val,
    input  logic [1:0]        prec_mode,
    input  logic [2:0]        op_class,
    input  logic [1:0]        rnd_mode,
    input  logic              lo_guard,
    input  logic              lo_sticky,
    input  logic              hi_guard,
    input  logic              hi_sticky,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_val,
    output logic              out_adj,
    output logic              out_reject
);

    localparam int LANE_W = DATA_W / 2;
    localparam int LANES  = 2;

    typedef struct packed {
        logic              vld;
        logic              rej;
        logic              adj;
        logic [DATA_W-1:0] val;
    } res_t;

    res_t res_d;
    res_t res_q;

    prec_e      prec;
    opc_e       opc;
    rnd_e       rnd;
    logic       sgn_lo;
    logic       sgn_hi;
    step_plan_t plan;

    logic [LANES-1:0]             lane_up;
    logic [LANES-1:0]             lane_dn;
    logic [LANES-1:0][LANE_W-1:0] lane_in;
    logic [LANES-1:0][LANE_W-1:0] lane_out;
    logic [DATA_W-1:0]            wide_inc;

    assign prec = prec_e'(prec_mode);
    assign opc  = opc_e'(op_class);
    assign rnd  = rnd_e'(rnd_mode);

    drc_sign_sel #(.LANE_W(LANE_W)) u_sign (
        .dest_lo      (dest_val[LANE_W-1:0]),
        .dest_hi_msb  (dest_val[DATA_W-1]),
        .dest_hi_zero (dest_val[DATA_W-1:LANE_W] == '0),
        .srcb_lo_msb  (srcb_val[LANE_W-1]),
        .srcb_hi_msb  (srcb_val[DATA_W-1]),
        .prec         (prec),
        .opc          (opc),
        .sgn_lo       (sgn_lo),
        .sgn_hi       (sgn_hi)
    );

    drc_step_plan u_plan (
        .prec   (prec),
        .opc    (opc),
        .rnd    (rnd),
        .inx_lo (lo_guard | lo_sticky),
        .inx_hi (hi_guard | hi_sticky),
        .sgn_lo (sgn_lo),
        .sgn_hi (sgn_hi),
        .plan   (plan)
    );

    assign lane_up = {plan.hi_up, plan.lo_up};
    assign lane_dn = {plan.hi_dn, plan.lo_dn};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_in[g] = dest_val[g*LANE_W +: LANE_W];
        drc_lane_step #(.W(LANE_W)) u_step (
            .val_in  (lane_in[g]),
            .step_up (lane_up[g]),
            .step_dn (lane_dn[g]),
            .val_out (lane_out[g])
        );
    end

    assign wide_inc = dest_val + DATA_W'(1);

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.rej = plan.reject;
            res_d.adj = plan.wide_up | (|lane_up) | (|lane_dn);
            res_d.val = plan.wide_up ? wide_inc : lane_out;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.vld;
    assign out_val    = res_q.val;
    assign out_adj    = res_q.adj;
    assign out_reject = res_q.rej;

endmodule

// File: rtl/drc_round_fix_chk.sv
module drc_round_fix_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] dest_val,
    input logic [1:0]        prec_mode,
    input logic [2:0]        op_class,
    input logic [1:0]        rnd_mode,
    input logic              lo_guard,
    input logic              lo_sticky,
    input logic              hi_guard,
    input logic              hi_sticky,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_val,
    input logic              out_adj,
    input logic              out_reject
);

    localparam int LANE_W = DATA_W / 2;

    logic gate_open;
    logic rej_in;
    assign gate_open = lo_guard | lo_sticky | ((prec_mode == 2'd2) & (hi_guard | hi_sticky));
    assign rej_in    = (op_class >= 3'd4) | (prec_mode == 2'd3);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    pass_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_mode < 2'd2) |=> (!out_adj && out_val == $past(dest_val)));
    // R3
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gate_open) |=> !out_adj);
    // R4
    trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 3'd1) |=> !out_adj);
    // R5
    unsigned_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 3'd2 && rnd_mode == 2'd3) |=> !out_adj);
    // R10
    dbl_int_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && prec_mode == 2'd1 && (op_class == 3'd2 || op_class == 3'd3))
        |=> out_val[DATA_W-1:LANE_W] == $past(dest_val[DATA_W-1:LANE_W]));
    // R12
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rej_in) |=> (out_reject && !out_adj && out_val == $past(dest_val)));
    // R13
    adj_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_adj == (out_val != $past(dest_val))));

endmodule

bind drc_round_fix drc_round_fix_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .dest_val   (dest_val),
    .prec_mode  (prec_mode),
    .op_class   (op_class),
    .rnd_mode   (rnd_mode),
    .lo_guard   (lo_guard),
    .lo_sticky  (lo_sticky),
    .hi_guard   (hi_guard),
    .hi_sticky  (hi_sticky),
    .out_valid  (out_valid),
    .out_val    (out_val),
    .out_adj    (out_adj),
    .out_reject (out_reject)
);

// File: tb/drc_round_fix_tb.sv
`timescale 1ns/1ps
module drc_round_fix_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] dest_val = '0;
    logic [63:0] srcb_val = '0;
    logic [1:0]  prec_mode = '0;
    logic [2:0]  op_class = '0;
    logic [1:0]  rnd_mode = '0;
    logic        lo_guard = 1'b0, lo_sticky = 1'b0, hi_guard = 1'b0, hi_sticky = 1'b0;
    logic        out_valid;
    logic [63:0] out_val;
    logic        out_adj;
    logic        out_reject;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    drc_round_fix #(.DATA_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .dest_val(dest_val), .srcb_val(srcb_val),
        .prec_mode(prec_mode), .op_class(op_class), .rnd_mode(rnd_mode),
        .lo_guard(lo_guard), .lo_sticky(lo_sticky),
        .hi_guard(hi_guard), .hi_sticky(hi_sticky),
        .out_valid(out_valid), .out_val(out_val),
        .out_adj(out_adj), .out_reject(out_reject)
    );

    // Independent model written from the requirements: {reject, adj, value}
    function automatic logic [65:0] model(input logic [63:0] d, input logic [63:0] b,
                                          input logic [1:0] pm, input logic [2:0] oc,
                                          input logic [1:0] rm, input logic ilo, input logic ihi);
        logic [63:0] v;
        logic rej, fp, uns, sgc, s;
        v   = d;
        rej = (oc >= 3'd4) || (pm == 2'd3);
        fp  = (oc == 3'd0);
        uns = (oc == 3'd2);
        sgc = (oc == 3'd3);
        if (!rej && rm >= 2'd2 && oc != 3'd1 && (ilo || (pm == 2'd2 && ihi))) begin
            if (pm == 2'd1 && fp) begin
                if ((rm == 2'd2 && !d[63]) || (rm == 2'd3 && d[63])) v = d + 64'd1;
            end else if (pm == 2'd1) begin
                s = uns ? 1'b0 : ((sgc && d[31:0] == 32'd0) ? b[63] : d[31]);
                if (rm == 2'd2 && !s) v[31:0] = d[31:0] + 32'd1;
                if (rm == 2'd3 && s)  v[31:0] = d[31:0] - 32'd1;
            end else begin
                for (int k = 0; k < 2; k++) begin
                    if ((k == 0 && ilo) || (k == 1 && ihi && pm == 2'd2)) begin
                        s = uns ? 1'b0 : ((sgc && d[k*32 +: 32] == 32'd0) ? b[k*32+31] : d[k*32+31]);
                        if (rm == 2'd2 && !s) v[k*32 +: 32] = d[k*32 +: 32] + 32'd1;
                        if (rm == 2'd3 && s)  v[k*32 +: 32] = fp ? d[k*32 +: 32] + 32'd1
                                                                 : d[k*32 +: 32] - 32'd1;
                    end
                end
            end
        end
        return {rej, (v != d), v};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one input, check the registered result one cycle later
    task automatic run(input string tag, input logic [63:0] d, input logic [63:0] b,
                       input logic [1:0] pm, input logic [2:0] oc, input logic [1:0] rm,
                       input logic lg, input logic ls, input logic hg, input logic hs,
                       input logic [63:0] exp_val, input bit use_exp);
        logic [65:0] m;
        @(negedge clk);
        dest_val = d; srcb_val = b; prec_mode = pm; op_class = oc; rnd_mode = rm;
        lo_guard = lg; lo_sticky = ls; hi_guard = hg; hi_sticky = hs; in_valid = 1'b1;
        m = model(d, b, pm, oc, rm, lg | ls, hg | hs);
        @(negedge clk);
        check({tag, " valid R1"}, {63'd0, out_valid}, 64'd1);
        check({tag, " value"}, out_val, use_exp ? exp_val : m[63:0]);
        check({tag, " adj R13"}, {63'd0, out_adj}, {63'd0, m[64]});
        check({tag, " reject R12"}, {63'd0, out_reject}, {63'd0, m[65]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, b;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset value", out_val, 64'd0);
        check("R1 reset adj", {63'd0, out_adj}, 64'd0);
        check("R1 reset reject", {63'd0, out_reject}, 64'd0);
        rst_n = 1'b1;

        // directed corners
        run("R2 nearest",   64'h1111_2222_3F80_0000, 0, 2'd0, 3'd0, 2'd0, 1,1,0,0, 64'h1111_2222_3F80_0000, 1);
        run("R2 zero",      64'h1111_2222_BF80_0000, 0, 2'd0, 3'd0, 2'd1, 1,0,0,0, 64'h1111_2222_BF80_0000, 1);
        run("R7 up fp",     64'hDEAD_BEEF_3F80_0000, 0, 2'd0, 3'd0, 2'd2, 1,0,0,0, 64'hDEAD_BEEF_3F80_0001, 1);
        run("R8 down fp",   64'h0000_0000_BF80_0000, 0, 2'd0, 3'd0, 2'd3, 0,1,0,0, 64'h0000_0000_BF80_0001, 1);
        run("R8 down int",  64'h0000_0000_FFFF_FFF0, 0, 2'd0, 3'd3, 2'd3, 1,0,0,0, 64'h0000_0000_FFFF_FFEF, 1);
        run("R6 zero neg",  64'h0, 64'h0000_0000_8000_0000, 2'd0, 3'd3, 2'd3, 1,0,0,0, 64'h0000_0000_FFFF_FFFF, 1);
        run("R6 zero pos",  64'h0, 64'h0, 2'd0, 3'd3, 2'd2, 1,0,0,0, 64'h0000_0000_0000_0001, 1);
        run("R6 zero negup",64'h0, 64'h0000_0000_8000_0000, 2'd0, 3'd3, 2'd2, 1,0,0,0, 64'h0, 1);
        run("R5 uns down",  64'h0000_0000_8000_0000, 0, 2'd0, 3'd2, 2'd3, 1,1,0,0, 64'h0000_0000_8000_0000, 1);
        run("R5 uns up",    64'h0000_0000_8000_0000, 0, 2'd0, 3'd2, 2'd2, 1,1,0,0, 64'h0000_0000_8000_0001, 1);
        run("R4 trunc",     64'h0000_0000_0000_0005, 0, 2'd0, 3'd1, 2'd2, 1,1,1,1, 64'h0000_0000_0000_0005, 1);
        run("R9 dbl carry", 64'h0000_0000_FFFF_FFFF, 0, 2'd1, 3'd0, 2'd2, 1,0,0,0, 64'h0000_0001_0000_0000, 1);
        run("R9 dbl neg",   64'hBFF0_0000_FFFF_FFFF, 0, 2'd1, 3'd0, 2'd3, 0,1,0,0, 64'hBFF0_0001_0000_0000, 1);
        run("R10 dbl int",  64'h1234_5678_0000_0000, 64'h8000_0000_0000_0000, 2'd1, 3'd3, 2'd3, 1,0,0,0, 64'h1234_5678_FFFF_FFFF, 1);
        run("R10 dbl wrap", 64'h0000_0000_FFFF_FFFF, 0, 2'd1, 3'd2, 2'd2, 1,0,0,0, 64'h0000_0000_0000_0000, 1);
        run("R11 lo only",  64'h0000_0001_0000_0001, 0, 2'd2, 3'd0, 2'd2, 1,0,0,0, 64'h0000_0001_0000_0002, 1);
        run("R11 hi only",  64'h0000_0001_0000_0001, 0, 2'd2, 3'd0, 2'd2, 0,0,0,1, 64'h0000_0002_0000_0001, 1);
        run("R11 no carry", 64'h0000_0000_FFFF_FFFF, 0, 2'd2, 3'd2, 2'd2, 1,0,0,0, 64'h0000_0000_0000_0000, 1);
        run("R11 hi zero",  64'h0000_0000_0000_0007, 64'h8000_0000_0000_0000, 2'd2, 3'd3, 2'd3, 0,0,1,0, 64'hFFFF_FFFF_0000_0007, 1);
        run("R3 sgl hi",    64'h0000_0001_0000_0001, 0, 2'd0, 3'd0, 2'd2, 0,0,1,1, 64'h0000_0001_0000_0001, 1);
        run("R3 exact",     64'h0000_0000_BF80_0000, 0, 2'd1, 3'd0, 2'd3, 0,0,1,1, 64'h0000_0000_BF80_0000, 1);
        run("R12 compare",  64'h0000_0000_0000_0001, 0, 2'd0, 3'd4, 2'd2, 1,1,1,1, 64'h0000_0000_0000_0001, 1);
        run("R12 prec3",    64'h0000_0000_0000_0001, 0, 2'd3, 3'd0, 2'd2, 1,1,1,1, 64'h0000_0000_0000_0001, 1);

        // drop valid: out_valid must fall one cycle later
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 valid drop", {63'd0, out_valid}, 64'd0);

        // random mix with biased zero lanes
        for (int i = 0; i < 3000; i++) begin
            d = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom % 3 == 0) d[31:0]  = 32'd0;
            if ($urandom % 3 == 0) d[63:32] = 32'd0;
            if ($urandom % 4 == 0) d[31:0]  = 32'hFFFF_FFFF;
            run("R6 R7 R8 R11 random", d, b, 2'($urandom), 3'($urandom % 6), 2'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 64'd0, 0);
        end

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule